// File: doc/BRIEF.md
# Armed External Sync Capture Controller

This block lines up the start of converter data movement with an external trigger. Software arms a one-shot capture through a small register port. The block then watches an external sync input that already runs on the converter clock. On the first rising edge after arming it raises a single-cycle start pulse that releases the datapath. While the block is armed and waiting, it holds the datapath in reset and reports a pending status bit. The arm bit clears itself when the trigger is taken.

A build parameter chooses between the armed external mode and a software-only mode. In software-only mode a sync bit written by software produces the start pulse directly, and the external input has no effect. The block has no data stream, so every pin is a plain control or status signal. The register port is a single-cycle write strobe with a combinational read of the addressed word.

Top module: `ext_sync_ctrl`

## Requirements
- R1: After reset, `pending`, `dp_rst` and `start` are all 0.
- R2: A write to address 0 with bit 0 set arms the block, and `pending` is 1 from the next cycle. While the block is armed, reading address 1 returns bit 0 = 1, and reading address 0 returns bit 0 = 1 until the arm bit clears itself.
- R3: `dp_rst` is 1 on every cycle in which the block is armed, and 0 otherwise.
- R4: A trigger is a cycle in which the block is armed, the registered previous sample of `sync_in` is 0, and the present `sync_in` is 1. A level that stays high never triggers. `start` is 1 on exactly the one cycle after the trigger cycle.
- R5: On the cycle in which `start` is 1, `pending` and `dp_rst` are already 0. The arm bit has cleared itself, and no further edge produces a pulse until the block is armed again.
- R6: A rising edge in the same cycle as the arm write is ignored. Only edges from the following cycle onward count.
- R7: An arm write while the block is already armed changes nothing and produces no pulse.
- R8: A write to address 0 with bit 1 set disarms the block without a pulse. Disarm wins over an arm bit in the same write, and over a trigger edge in the same cycle.
- R9: In external mode (`EXT_SYNC_EN`=1), a write of the software sync bit (address 0, bit 2) has no effect.
- R10: In software mode (`EXT_SYNC_EN`=0), a write with bit 2 set gives a one-cycle `start` on the next cycle. Arm and disarm bits and `sync_in` edges have no effect, and `pending` and `dp_rst` stay 0.
- R11: A read of any address other than 0 and 1 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Word address for the write or the read |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data of `reg_addr` |
| sync_in | input | 1 | External sync, synchronous to `clk` |
| start | output | 1 | One-cycle pulse that releases the datapath |
| dp_rst | output | 1 | Datapath reset, held while armed |
| pending | output | 1 | Armed and no edge seen yet |

## Verification
The bench builds two copies of the block from the same stimulus: one with `EXT_SYNC_EN`=1 and one with `EXT_SYNC_EN`=0. The external copy covers arming, edge versus level, the self-clearing arm bit, and the races of an edge against the arm write and against the disarm write. The software copy shows that the direct sync bit pulses at once while arming and external edges do nothing. `ADDR_W`=4 leaves unmapped addresses that can be read back as zero.

// File: rtl/ext_sync_pkg.sv
package ext_sync_pkg;
  localparam int unsigned CTRL_ADDR  = 0;
  localparam int unsigned STAT_ADDR  = 1;
  localparam int unsigned ARM_BIT    = 0;
  localparam int unsigned DISARM_BIT = 1;
  localparam int unsigned SWSYNC_BIT = 2;
  localparam int unsigned CTRL_BITS  = 3;
endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_in;
  end

  assign rise = sig_in & ~prev_q;
endmodule

// File: rtl/sync_regs.sv
module sync_regs
  import ext_sync_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              armed,
  output logic [DATA_W-1:0] rdata,
  output logic              arm_req,
  output logic              disarm_req,
  output logic              sw_req
);
  logic ctrl_hit;
  logic unused_wdata;

  assign ctrl_hit   = wr && (addr == ADDR_W'(CTRL_ADDR));
  assign arm_req    = ctrl_hit && wdata[ARM_BIT];
  assign disarm_req = ctrl_hit && wdata[DISARM_BIT];
  assign sw_req     = ctrl_hit && wdata[SWSYNC_BIT];

  generate
    if (DATA_W > CTRL_BITS) begin : g_spare
      assign unused_wdata = ^wdata[DATA_W-1:CTRL_BITS];
    end else begin : g_nospare
      assign unused_wdata = 1'b0;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(CTRL_ADDR))      rdata[ARM_BIT] = armed;
    else if (addr == ADDR_W'(STAT_ADDR)) rdata[0]       = armed;
  end
endmodule

// File: rtl/sync_arm_ctl.sv
module sync_arm_ctl #(
  parameter bit EXT_SYNC_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_req,
  input  logic disarm_req,
  input  logic sw_req,
  input  logic edge_seen,
  output logic armed,
  output logic start
);
  generate
    if (EXT_SYNC_EN) begin : g_ext
      logic armed_q, start_q;
      logic unused_sw;
      assign unused_sw = sw_req;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          armed_q <= 1'b0;
          start_q <= 1'b0;
        end else begin
          start_q <= 1'b0;
          if (disarm_req) begin
            armed_q <= 1'b0;
          end else if (armed_q && edge_seen) begin
            armed_q <= 1'b0;
            start_q <= 1'b1;
          end else if (arm_req) begin
            armed_q <= 1'b1;
          end
        end
      end
      assign armed = armed_q;
      assign start = start_q;
    end else begin : g_sw
      logic start_q;
      logic unused_ext;
      assign unused_ext = ^{arm_req, disarm_req, edge_seen};

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= sw_req;
      end
      assign armed = 1'b0;
      assign start = start_q;
    end
  endgenerate
endmodule

// File: rtl/ext_sync_ctrl.sv
module ext_sync_ctrl #(
  parameter bit          EXT_SYNC_EN = 1'b1,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sync_in,
  output logic              start,
  output logic              dp_rst,
  output logic              pending
);
  logic arm_req, disarm_req, sw_req, rise, armed;

  sync_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .armed(armed),
    .rdata(reg_rdata), .arm_req(arm_req), .disarm_req(disarm_req),
    .sw_req(sw_req)
  );

  sync_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .sig_in(sync_in), .rise(rise)
  );

  sync_arm_ctl #(.EXT_SYNC_EN(EXT_SYNC_EN)) u_arm (
    .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .disarm_req(disarm_req),
    .sw_req(sw_req), .edge_seen(rise), .armed(armed), .start(start)
  );

  assign dp_rst  = armed;
  assign pending = armed;
endmodule

// File: rtl/ext_sync_ctrl_chk.sv
module ext_sync_ctrl_chk #(
  parameter bit          EXT_SYNC_EN = 1'b1,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              sync_in,
  input logic              start,
  input logic              dp_rst,
  input logic              pending
);
  logic ctrl_wr;
  assign ctrl_wr = reg_wr && (reg_addr == '0);

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (EXT_SYNC_EN && start) |=> !start);                                  // R4
  AST_FIRE_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (EXT_SYNC_EN && start) |-> $past(pending));                          // R4
  AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!pending && !dp_rst));                                    // R5
  AST_EDGE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (EXT_SYNC_EN && pending && sync_in && !$past(sync_in)
     && !(ctrl_wr && reg_wdata[1])) |=> start);                          // R4
  AST_ARM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (EXT_SYNC_EN && !pending && ctrl_wr && reg_wdata[0] && !reg_wdata[1])
    |=> pending);                                                        // R2
  AST_DISARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (EXT_SYNC_EN && ctrl_wr && reg_wdata[1]) |=> (!start && !pending));  // R8
  AST_SW_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !EXT_SYNC_EN |-> (!dp_rst && !pending));                             // R10
endmodule

bind ext_sync_ctrl ext_sync_ctrl_chk #(
  .EXT_SYNC_EN(EXT_SYNC_EN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .sync_in(sync_in), .start(start),
  .dp_rst(dp_rst), .pending(pending)
);

// File: tb/ext_sync_ctrl_tb.sv
`timescale 1ns/1ps
module ext_sync_ctrl_tb;
  localparam int AW = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic sync_in = 1'b0;
  logic [DW-1:0] rd_e, rd_s;
  logic start_e, dprst_e, pend_e, start_s, dprst_s, pend_s;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ext_sync_ctrl #(.EXT_SYNC_EN(1'b1), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rd_e), .sync_in(sync_in),
    .start(start_e), .dp_rst(dprst_e), .pending(pend_e));

  ext_sync_ctrl #(.EXT_SYNC_EN(1'b0), .ADDR_W(AW), .DATA_W(DW)) u_dut_sw (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rd_s), .sync_in(sync_in),
    .start(start_s), .dp_rst(dprst_s), .pending(pend_s));

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // one write; returns at the negedge after the capturing posedge
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; reg_addr = '0;
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic rd_ext(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                        input string what);
    reg_addr = a; #0.5;
    chk(rd_e, exp, what);
    reg_addr = '0;
  endtask

  task automatic t_reset();
    chk({29'd0, pend_e, dprst_e, start_e}, 0, "R1 ext outputs after reset");
    chk({29'd0, pend_s, dprst_s, start_s}, 0, "R1 sw outputs after reset");
  endtask

  task automatic t_arm_fire();
    wr(0, 32'h1);
    chk(pend_e, 1, "R2 pending after arm");
    rd_ext(1, 1, "R2 status read");
    rd_ext(0, 1, "R2 ctrl arm bit reads set");
    chk(dprst_e, 1, "R3 reset held while armed");
    tick(); tick();
    chk(start_e, 0, "R4 no pulse with sync low");
    sync_in = 1'b1; tick();
    chk(start_e, 1, "R4 pulse after rising edge");
    chk(pend_e, 0, "R5 pending cleared with pulse");
    chk(dprst_e, 0, "R5 reset released with pulse");
    rd_ext(0, 0, "R5 arm bit cleared itself");
    tick();
    chk(start_e, 0, "R4 pulse lasts one cycle");
    sync_in = 1'b0; tick(); sync_in = 1'b1; tick();
    chk(start_e, 0, "R5 no pulse after trigger without rearm");
  endtask

  task automatic t_level();
    wr(0, 32'h1); tick(); tick();
    chk(start_e, 0, "R4 high level does not trigger");
    chk(pend_e, 1, "R4 still pending on level");
    sync_in = 1'b0; tick(); sync_in = 1'b1; tick();
    chk(start_e, 1, "R4 fresh edge triggers");
    sync_in = 1'b0; tick();
  endtask

  task automatic t_same_cycle();
    sync_in = 1'b1;
    wr(0, 32'h1);
    chk(start_e, 0, "R6 edge in arm cycle ignored");
    chk(pend_e, 1, "R6 armed after edge in arm cycle");
    tick();
    chk(start_e, 0, "R6 no late pulse");
    sync_in = 1'b0; tick(); sync_in = 1'b1; tick();
    chk(start_e, 1, "R6 later edge triggers");
    sync_in = 1'b0; tick();
  endtask

  task automatic t_rearm();
    wr(0, 32'h1);
    wr(0, 32'h1);
    chk(start_e, 0, "R7 rearm gives no pulse");
    chk(pend_e, 1, "R7 still armed after rearm");
    sync_in = 1'b1; tick();
    chk(start_e, 1, "R7 single trigger still works");
    sync_in = 1'b0; tick();
  endtask

  task automatic t_disarm();
    wr(0, 32'h1);
    wr(0, 32'h2);
    chk({start_e, pend_e, dprst_e}, 0, "R8 disarm clears without pulse");
    sync_in = 1'b1; tick();
    chk(start_e, 0, "R8 edge after disarm ignored");
    sync_in = 1'b0; tick();
    wr(0, 32'h3);
    chk(pend_e, 0, "R8 disarm wins over arm");
    wr(0, 32'h1);
    sync_in = 1'b1;
    wr(0, 32'h2);
    chk({start_e, pend_e}, 0, "R8 disarm wins over edge");
    tick();
    chk(start_e, 0, "R8 no pulse after disarm race");
    sync_in = 1'b0; tick();
  endtask

  task automatic t_sw_bit_ext();
    wr(0, 32'h4);
    chk({start_e, pend_e}, 0, "R9 sw sync bit ignored in ext mode");
    tick();
    chk(start_e, 0, "R9 no delayed pulse");
  endtask

  task automatic t_sw_mode();
    wr(0, 32'h4);
    chk(start_s, 1, "R10 sw sync gives pulse");
    tick();
    chk(start_s, 0, "R10 sw pulse is one cycle");
    wr(0, 32'h1);
    chk({pend_s, dprst_s}, 0, "R10 arm ignored in sw mode");
    sync_in = 1'b1; tick();
    chk(start_s, 0, "R10 edge ignored in sw mode");
    chk(start_e, 1, "R4 ext copy fires on same edge");
    sync_in = 1'b0; tick();
  endtask

  task automatic t_unmapped();
    rd_ext(5, 0, "R11 unmapped read zero");
    rd_ext(15, 0, "R11 top address read zero");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_arm_fire();
    t_level();
    t_same_cycle();
    t_rearm();
    t_disarm();
    t_sw_bit_ext();
    t_sw_mode();
    t_unmapped();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule